// File: doc/BRIEF.md
# Digital Input Change Event Register

This block watches fifteen digital input lines and turns selected changes on them into latched events. The live level of the lines is the condition value. Each line has its own rising-edge mask and falling-edge mask. An edge that passes its mask sets a sticky event bit. The event bit stays set until the host reads the event register, and that read clears it. A third mask, the summary enable, selects which event bits may raise the single service-request output. That output is meant to feed one bit of a wider status byte.

The host sees five 16-bit registers through a simple strobe interface. `host_rd` and `host_wr` are single-cycle strobes qualified by `host_addr`. Read data is combinational from the addressed register. Side effects take place at the clock edge that ends the strobe cycle.

Register selects:
- Condition = 0
- Event = 1
- Rising mask = 2
- Falling mask = 3
- Summary enable = 4

Any other select reads zero. Edges are found by comparing the current input with the value registered on the previous clock. The inputs must already be synchronous to `clk`. Debouncing is not part of this block.

Top module: `dio_event_status`

## Requirements
- R1: Reading select 0 returns `line_in` in bits 0 to 14 in the same cycle.
- R2: If a line goes 0 to 1 between two consecutive clocks and its rising-mask bit is 1, its event bit is 1 after that second clock.
- R3: If a line goes 1 to 0 between two consecutive clocks and its falling-mask bit is 1, its event bit is 1 after that second clock.
- R4: With both mask bits set, any change of the line sets its event bit. With neither set, no change of the line sets it.
- R5: A read strobe at select 1 returns the event bits in that cycle. Those bits are zero after the clock edge that ends the strobe.
- R6: A qualifying edge seen in the same cycle as an event read leaves its event bit set after the clear.
- R7: `srv_req` is 1 exactly when some bit has both its event bit and its summary-enable bit set. It follows mask writes and event reads on the next clock.
- R8: Bit 15 of every register reads 0, and a write to bit 15 has no effect.
- R9: After reset the masks read as follows: rising 0x7FFF, falling 0x0000, summary enable 0x0000. The event register is 0, and input levels held during reset do not produce events.
- R10: An event bit stays set, whatever the line does later, until the event register is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 15 | Synchronized digital input lines |
| host_addr | input | 3 | Register select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (clears events at select 1) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from select |
| srv_req | output | 1 | Summary of enabled events |

## Verification
The bench visits every line with all four mask settings and drives a rise and then a fall on each. This catches a design that swaps the polarity of the masks, or that lets one line's edge set a neighbouring bit. It makes an edge arrive in the same cycle as an event read; a design that clears after merging, instead of before, would lose that event. It holds inputs high through reset, so a design whose edge history starts at zero would report false rising events. It writes all ones and expects bit 15 to stay zero. It also checks that the summary output follows only the events whose enable bits are set.

// File: rtl/dio_event_pkg.sv
// Shared register selects for the digital input event block.
// Assumes a 3-bit select; values outside the list read as zero.
package dio_event_pkg;
    typedef enum logic [2:0] {
        SEL_COND  = 3'd0,
        SEL_EVENT = 3'd1,
        SEL_RISE  = 3'd2,
        SEL_FALL  = 3'd3,
        SEL_SUMEN = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/dio_edge_detect.sv
// Finds rising and falling transitions of each input line.
// Assumes inputs are synchronous to clk. The history register loads the live
// value during reset too, so levels present at reset release are not edges.
module dio_edge_detect #(
    parameter int N_LINES = 15
) (
    input  logic               clk,
    input  logic [N_LINES-1:0] line_in,
    output logic [N_LINES-1:0] rise,
    output logic [N_LINES-1:0] fall
);
    logic [N_LINES-1:0] prev_q;

    // Keep the previous-clock value of every line (also tracked in reset).
    always_ff @(posedge clk) begin
        prev_q <= line_in;
    end

    // Compare live value with history to form edge flags.
    always_comb begin
        rise = line_in & ~prev_q;
        fall = ~line_in & prev_q;
    end
endmodule

// File: rtl/dio_event_latch.sv
// Per-line sticky event bits fed by masked edges, cleared by a read strobe.
// An edge in the same cycle as the clear wins: clear first, then merge.
module dio_event_latch #(
    parameter int N_LINES = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] rise,
    input  logic [N_LINES-1:0] fall,
    input  logic [N_LINES-1:0] rise_mask,
    input  logic [N_LINES-1:0] fall_mask,
    input  logic               clr,
    output logic [N_LINES-1:0] evt
);
    for (genvar b = 0; b < N_LINES; b++) begin : g_bit
        logic hit;
        logic bit_q;

        // Qualify this line's edges against its two masks.
        always_comb hit = (rise[b] & rise_mask[b]) | (fall[b] & fall_mask[b]);

        // Hold the event until read; new hits survive a same-cycle read.
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~clr) | hit;
        end

        assign evt[b] = bit_q;
    end
endmodule

// File: rtl/dio_host_regs.sv
// Host-writable masks plus the read mux over all five registers.
// Assumes one-cycle strobes; unused upper bits are forced to zero.
module dio_host_regs
    import dio_event_pkg::*;
#(
    parameter int N_LINES = 15,
    parameter int REG_W   = 16,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [REG_W-1:0]   host_wdata,
    input  logic [N_LINES-1:0] cond,
    input  logic [N_LINES-1:0] evt,
    output logic [N_LINES-1:0] rise_mask,
    output logic [N_LINES-1:0] fall_mask,
    output logic [N_LINES-1:0] sum_en,
    output logic               evt_clr,
    output logic [REG_W-1:0]   host_rdata
);
    localparam int PAD = REG_W - N_LINES;

    logic [N_LINES-1:0] wr_bits;
    logic [N_LINES-1:0] rd_bits;

    assign wr_bits = host_wdata[N_LINES-1:0];
    assign evt_clr = host_rd && (host_addr == ADDR_W'(SEL_EVENT));

    // Mask registers: reset defaults, then host writes by select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_mask <= '1;
            fall_mask <= '0;
            sum_en    <= '0;
        end else if (host_wr) begin
            if (host_addr == ADDR_W'(SEL_RISE))  rise_mask <= wr_bits;
            if (host_addr == ADDR_W'(SEL_FALL))  fall_mask <= wr_bits;
            if (host_addr == ADDR_W'(SEL_SUMEN)) sum_en    <= wr_bits;
        end
    end

    // Select the register addressed by the host.
    always_comb begin
        case (host_addr)
            ADDR_W'(SEL_COND):  rd_bits = cond;
            ADDR_W'(SEL_EVENT): rd_bits = evt;
            ADDR_W'(SEL_RISE):  rd_bits = rise_mask;
            ADDR_W'(SEL_FALL):  rd_bits = fall_mask;
            ADDR_W'(SEL_SUMEN): rd_bits = sum_en;
            default:            rd_bits = '0;
        endcase
    end

    assign host_rdata = {{PAD{1'b0}}, rd_bits};
endmodule

// File: rtl/dio_event_status.sv
// Top: condition, transition filter, sticky events and summary request.
// Assumes line_in already synchronized; REG_W must exceed N_LINES.
module dio_event_status #(
    parameter int N_LINES = 15,
    parameter int REG_W   = 16,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    output logic               srv_req
);
    logic [N_LINES-1:0] rise_v, fall_v;
    logic [N_LINES-1:0] rise_mask, fall_mask, sum_en;
    logic [N_LINES-1:0] evt_q;
    logic               evt_clr;

    dio_edge_detect #(.N_LINES(N_LINES)) u_edge (
        .clk     (clk),
        .line_in (line_in),
        .rise    (rise_v),
        .fall    (fall_v)
    );

    dio_event_latch #(.N_LINES(N_LINES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise_v),
        .fall      (fall_v),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .clr       (evt_clr),
        .evt       (evt_q)
    );

    dio_host_regs #(.N_LINES(N_LINES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .cond       (line_in),
        .evt        (evt_q),
        .rise_mask  (rise_mask),
        .fall_mask  (fall_mask),
        .sum_en     (sum_en),
        .evt_clr    (evt_clr),
        .host_rdata (host_rdata)
    );

    // Summary request: any event whose enable bit is set.
    always_comb srv_req = |(evt_q & sum_en);
endmodule

// File: rtl/dio_event_status_chk.sv
// Property checker for dio_event_status, attached by bind below.
module dio_event_status_chk #(
    parameter int N_LINES = 15,
    parameter int REG_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] rise_v,
    input logic [N_LINES-1:0] fall_v,
    input logic [N_LINES-1:0] rise_mask,
    input logic [N_LINES-1:0] fall_mask,
    input logic [N_LINES-1:0] sum_en,
    input logic [N_LINES-1:0] evt_q,
    input logic               evt_clr,
    input logic [REG_W-1:0]   host_rdata,
    input logic               srv_req
);
    logic [N_LINES-1:0] rhit, fhit, anyhit;
    assign rhit   = rise_v & rise_mask;
    assign fhit   = fall_v & fall_mask;
    assign anyhit = rhit | fhit;

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rhit != '0) |=> ((evt_q & $past(rhit)) == $past(rhit)));                    // R2
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (fhit != '0) |=> ((evt_q & $past(fhit)) == $past(fhit)));                    // R3
    AST_NO_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (anyhit == '0 && !evt_clr) |=> $stable(evt_q));                              // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && anyhit == '0) |=> (evt_q == '0));                                // R5
    AST_EDGE_OUTLIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && anyhit != '0) |=> ((evt_q & $past(anyhit)) == $past(anyhit)));   // R6
    AST_SUMMARY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & sum_en) == '0) |-> !srv_req);                                      // R7
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[REG_W-1] == 1'b0);                                                // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));                      // R10
endmodule

bind dio_event_status dio_event_status_chk #(.N_LINES(N_LINES), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_v     (rise_v),
    .fall_v     (fall_v),
    .rise_mask  (rise_mask),
    .fall_mask  (fall_mask),
    .sum_en     (sum_en),
    .evt_q      (evt_q),
    .evt_clr    (evt_clr),
    .host_rdata (host_rdata),
    .srv_req    (srv_req)
);

// File: tb/dio_event_status_test.sv
`timescale 1ns/1ps
module dio_event_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] line_in = '0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        srv_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dio_event_status uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .srv_req(srv_req)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_lines(input logic [14:0] v);
        @(negedge clk);
        line_in = v;
    endtask

    initial begin
        logic [15:0] d;
        // R9: levels held high through reset must not become events
        line_in = 15'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_reg(3'd1, d); check("R9 event after reset", d, 16'h0000);
        rd_reg(3'd2, d); check("R9 rise mask reset", d, 16'h7FFF);
        rd_reg(3'd3, d); check("R9 fall mask reset", d, 16'h0000);
        rd_reg(3'd4, d); check("R9 enable reset", d, 16'h0000);
        check("R9 srv_req reset", {15'd0, srv_req}, 16'h0000);

        // R1: condition follows the lines
        for (int k = 0; k < 8; k++) begin
            logic [14:0] p;
            p = 15'(16'h1357 * (k + 1) ^ (16'h0F0F << k));
            set_lines(p);
            rd_reg(3'd0, d); check("R1 condition", d, {1'b0, p});
        end
        rd_reg(3'd5, d); check("R1 unused select", d, 16'h0000);
        set_lines('0);
        rd_reg(3'd1, d);

        // R2 R3 R4: every line with each mask setting, rise then fall
        for (int i = 0; i < 15; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] bitv;
                bitv = 16'(1) << i;
                wr_reg(3'd2, (m & 1) != 0 ? bitv : 16'h0);
                wr_reg(3'd3, (m & 2) != 0 ? bitv : 16'h0);
                set_lines(15'(bitv));
                rd_reg(3'd1, d); check("R2/R4 rise", d, (m & 1) != 0 ? bitv : 16'h0);
                set_lines('0);
                rd_reg(3'd1, d); check("R3/R4 fall", d, (m & 2) != 0 ? bitv : 16'h0);
            end
        end

        // R8: bit 15 ignores writes
        wr_reg(3'd2, 16'hFFFF);
        rd_reg(3'd2, d); check("R8 rise mask bit15", d, 16'h7FFF);
        wr_reg(3'd4, 16'h8000);
        rd_reg(3'd4, d); check("R8 enable bit15", d, 16'h0000);

        // R10: event stays after the line returns, until read
        wr_reg(3'd3, 16'h0000);
        set_lines(15'h0010);
        set_lines(15'h0000);
        repeat (3) @(negedge clk);
        rd_reg(3'd1, d); check("R10 sticky", d, 16'h0010);
        rd_reg(3'd1, d); check("R5 cleared by read", d, 16'h0000);

        // R6: edge in the same cycle as the read survives
        @(negedge clk);
        host_addr = 3'd1; host_rd = 1'b1; line_in = 15'h0004;
        #1 check("R6 read data before edge", host_rdata, 16'h0000);
        @(negedge clk);
        host_rd = 1'b0;
        rd_reg(3'd1, d); check("R6 edge kept", d, 16'h0004);
        set_lines('0);

        // R7: summary from rising line 0 and falling line 1
        wr_reg(3'd2, 16'h0001);
        wr_reg(3'd3, 16'h0002);
        set_lines(15'h0002);
        @(negedge clk);
        rd_reg(3'd1, d); check("R4 masked rise ignored", d, 16'h0000);
        set_lines(15'h0001);
        @(negedge clk);
        check("R7 no enable", {15'd0, srv_req}, 16'h0000);
        wr_reg(3'd4, 16'h0004);
        check("R7 other enable", {15'd0, srv_req}, 16'h0000);
        wr_reg(3'd4, 16'h0002);
        check("R7 falling enabled", {15'd0, srv_req}, 16'h0001);
        wr_reg(3'd4, 16'h0001);
        check("R7 rising enabled", {15'd0, srv_req}, 16'h0001);
        rd_reg(3'd1, d); check("R5 event value", d, 16'h0003);
        check("R7 drops after read", {15'd0, srv_req}, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule